// File: doc/BRIEF.md
# Idle-State Exit Sequencer

This block brings a processor out of a stop-clock idle state and back to executing code. An entry controller elsewhere parks the processor and raises a one-cycle park strobe. On that strobe the sequencer asserts the active-low stop-clock output and holds the latched processor interface lines. When a break event then arrives, the sequencer runs a fixed, ordered wake handshake. It waits a programmed delay and sends one go-running request pulse toward the memory-controller side. It then stalls until that side returns a running acknowledge. After a second delay it deasserts stop-clock, so the processor can resume fetching instructions. After a third delay it releases the held interface lines and becomes ready for the next park.

The three gaps come from configuration inputs and count in clock cycles. A value of zero lets the step proceed on the next cycle. The system-management interrupt line is never held: it is not latched for synchronous events, so it plays no part in the release. The block also raises a wake-block level toward the memory-controller side. This level runs from the go-running request until the release step, and while it is high that side must not raise its own wake indication.

Top module: `idle_exit_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stop_clk_n_o` is 1 and `go_req_o` is 0, `wake_blk_o` is 0 and `hold_o` is all zeros.
- R2: A `park_i` pulse sampled while the block is running drives `stop_clk_n_o` low from the next cycle. On that same cycle it sets every `hold_o` bit except bit `SMGT_IDX`.
- R3: A `break_i` sampled high in the parked state makes `go_req_o` high for exactly one cycle. That cycle begins `go_dly_i`+1 clock edges after the edge that sampled the break.
- R4: After the go-running request, `stop_clk_n_o` stays low until `ack_i` is sampled high. It then rises `run_dly_i`+1 edges after the edge that sampled the acknowledge.
- R5: All of `hold_o` clears `rel_dly_i`+1 edges after the edge on which `stop_clk_n_o` rose. The block then accepts a new `park_i`.
- R6: Bit `SMGT_IDX` of `hold_o` (the system-management interrupt line, bit 0 by default) is never 1.
- R7: `wake_blk_o` rises on the same cycle as the `go_req_o` pulse. It stays high until the cycle on which `hold_o` clears, and it falls on that cycle.
- R8: The block ignores `break_i` and `ack_i` while it is running. It ignores `ack_i` while it is parked and no request has been sent. It ignores `break_i` and `park_i` while a wake sequence is in progress. None of these produces a request, a change of `stop_clk_n_o` or a change of `hold_o`.
- R9: A delay input of zero makes its step happen on the edge right after the one that started the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| park_i | input | 1 | One-cycle strobe: the processor has been parked in idle |
| break_i | input | 1 | Break (wake) event |
| ack_i | input | 1 | Running acknowledge from the memory-controller side |
| go_dly_i | input | DLY_W | Cycles from break to go-running request, minus one |
| run_dly_i | input | DLY_W | Cycles from acknowledge to stop-clock deassertion, minus one |
| rel_dly_i | input | DLY_W | Cycles from stop-clock deassertion to release, minus one |
| go_req_o | output | 1 | One-cycle go-running request pulse |
| stop_clk_n_o | output | 1 | Active-low stop-clock to the processor |
| wake_blk_o | output | 1 | Memory-controller side must not raise a wake indication |
| hold_o | output | NLAT | Per-line hold of latched processor interface signals |

## Verification
The assertions assume that `park_i` and `break_i` are single-cycle or short strobes and that `ack_i` arrives only in answer to a request. They also assume the delay inputs stay stable for the whole of one wake sequence. The stimulus changes the delay inputs only between sequences, while the block is running, and pulses every strobe for one cycle from the falling edge. It also injects the stray breaks, acknowledges and park strobes that the block must ignore, both while running and in the middle of a sequence.

// File: rtl/idle_exit_pkg.sv
package idle_exit_pkg;

    localparam int DEF_DLY_W = 6;
    localparam int DEF_NLAT  = 4;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_PARKED   = 3'd1,
        ST_GO_WAIT  = 3'd2,
        ST_ACK_WAIT = 3'd3,
        ST_RUN_WAIT = 3'd4,
        ST_REL_WAIT = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic go_req;
        logic stop_clk_n;
        logic wake_blk;
    } seq_out_t;

    localparam seq_out_t SEQ_OUT_RESET = '{go_req: 1'b0, stop_clk_n: 1'b1, wake_blk: 1'b0};

    function automatic logic seq_busy(input seq_state_e st);
        return st inside {ST_GO_WAIT, ST_ACK_WAIT, ST_RUN_WAIT, ST_REL_WAIT};
    endfunction

endpackage

// File: rtl/ies_delay_cnt.sv
module ies_delay_cnt #(
    parameter int DLY_W = idle_exit_pkg::DEF_DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             zero
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R9: an idle counter at zero stays there and never wraps
    p_cnt_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

endmodule

// File: rtl/ies_hold_bank.sv
module ies_hold_bank #(
    parameter int NLAT     = idle_exit_pkg::DEF_NLAT,
    parameter int SMGT_IDX = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            latch,
    input  logic            release_all,
    output logic [NLAT-1:0] hold
);
    for (genvar i = 0; i < NLAT; i++) begin : g_line
        if (i == SMGT_IDX) begin : g_free
            assign hold[i] = 1'b0;
        end else begin : g_held
            logic h_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    h_q <= 1'b0;
                end else if (latch) begin
                    h_q <= 1'b1;
                end else if (release_all) begin
                    h_q <= 1'b0;
                end
            end
            assign hold[i] = h_q;
        end
    end

    // R6: the system-management interrupt line never becomes held
    p_smgt_never_held_r6: assert property (@(posedge clk) disable iff (rst)
        hold[SMGT_IDX] == 1'b0);

endmodule

// File: rtl/ies_fsm.sv
module ies_fsm
    import idle_exit_pkg::*;
#(
    parameter int DLY_W = DEF_DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             park,
    input  logic             brk,
    input  logic             ack,
    input  logic [DLY_W-1:0] go_dly,
    input  logic [DLY_W-1:0] run_dly,
    input  logic [DLY_W-1:0] rel_dly,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [DLY_W-1:0] cnt_val,
    output logic             latch,
    output logic             release_all,
    output seq_out_t         outs
);
    seq_state_e st;

    always_comb begin
        cnt_load    = 1'b0;
        cnt_val     = '0;
        latch       = 1'b0;
        release_all = 1'b0;
        case (st)
            ST_RUN:      latch = park;
            ST_PARKED: begin
                cnt_load = brk;
                cnt_val  = go_dly;
            end
            ST_ACK_WAIT: begin
                cnt_load = ack;
                cnt_val  = run_dly;
            end
            ST_RUN_WAIT: begin
                cnt_load = cnt_zero;
                cnt_val  = rel_dly;
            end
            ST_REL_WAIT: release_all = cnt_zero;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_RUN;
            outs <= SEQ_OUT_RESET;
        end else begin
            outs.go_req <= 1'b0;
            case (st)
                ST_RUN: if (park) begin
                    st              <= ST_PARKED;
                    outs.stop_clk_n <= 1'b0;
                end
                ST_PARKED: if (brk) begin
                    st <= ST_GO_WAIT;
                end
                ST_GO_WAIT: if (cnt_zero) begin
                    st            <= ST_ACK_WAIT;
                    outs.go_req   <= 1'b1;
                    outs.wake_blk <= 1'b1;
                end
                ST_ACK_WAIT: if (ack) begin
                    st <= ST_RUN_WAIT;
                end
                ST_RUN_WAIT: if (cnt_zero) begin
                    st              <= ST_REL_WAIT;
                    outs.stop_clk_n <= 1'b1;
                end
                ST_REL_WAIT: if (cnt_zero) begin
                    st            <= ST_RUN;
                    outs.wake_blk <= 1'b0;
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    // R3: the go-running request is a single-cycle pulse
    p_go_single_r3: assert property (@(posedge clk) disable iff (rst)
        outs.go_req |=> !outs.go_req);

    // R7: the wake-block window opens together with the request
    p_block_opens_with_go_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.wake_blk) |-> outs.go_req);

    // R4: stop-clock is only released inside an open wake window
    p_resume_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.stop_clk_n) |-> outs.wake_blk);

    // R8: a sequence in progress never re-enters the parked state on a new park strobe
    p_no_repark_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_busy(st) && park) |=> (st != ST_PARKED));

endmodule

// File: rtl/idle_exit_seq.sv
module idle_exit_seq
    import idle_exit_pkg::*;
#(
    parameter int DLY_W    = DEF_DLY_W,
    parameter int NLAT     = DEF_NLAT,
    parameter int SMGT_IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             park_i,
    input  logic             break_i,
    input  logic             ack_i,
    input  logic [DLY_W-1:0] go_dly_i,
    input  logic [DLY_W-1:0] run_dly_i,
    input  logic [DLY_W-1:0] rel_dly_i,
    output logic             go_req_o,
    output logic             stop_clk_n_o,
    output logic             wake_blk_o,
    output logic [NLAT-1:0]  hold_o
);
    logic             cnt_load;
    logic [DLY_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             latch;
    logic             release_all;
    seq_out_t         outs;

    ies_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .park       (park_i),
        .brk        (break_i),
        .ack        (ack_i),
        .go_dly     (go_dly_i),
        .run_dly    (run_dly_i),
        .rel_dly    (rel_dly_i),
        .cnt_zero   (cnt_zero),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .latch      (latch),
        .release_all(release_all),
        .outs       (outs)
    );

    ies_delay_cnt #(.DLY_W(DLY_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (cnt_load),
        .load_val(cnt_val),
        .zero    (cnt_zero)
    );

    ies_hold_bank #(.NLAT(NLAT), .SMGT_IDX(SMGT_IDX)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .latch      (latch),
        .release_all(release_all),
        .hold       (hold_o)
    );

    assign go_req_o     = outs.go_req;
    assign stop_clk_n_o = outs.stop_clk_n;
    assign wake_blk_o   = outs.wake_blk;

    // R1: reset leaves the block running with nothing outstanding
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (stop_clk_n_o && !go_req_o && !wake_blk_o && (hold_o == '0)));

    // R5: held lines are released only once the processor is running again
    p_release_after_resume_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(|hold_o) |-> (stop_clk_n_o && !wake_blk_o));

    // R2: parking asserts stop-clock while lines become held
    p_park_holds_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_clk_n_o) |-> (hold_o != '0));

endmodule

// File: tb/idle_exit_seq_bench.sv
module idle_exit_seq_bench;
    localparam int DLY_W    = 6;
    localparam int NLAT     = 4;
    localparam int SMGT_IDX = 0;
    localparam logic [NLAT-1:0] PARK_MASK = NLAT'((1 << NLAT) - 1) & ~NLAT'(1 << SMGT_IDX);

    localparam int EV_PARK = 0;
    localparam int EV_GO   = 1;
    localparam int EV_RUN  = 2;
    localparam int EV_REL  = 3;

    typedef struct {
        int kind;
        int cyc;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             park_i = 1'b0;
    logic             break_i = 1'b0;
    logic             ack_i = 1'b0;
    logic [DLY_W-1:0] go_dly_i = '0;
    logic [DLY_W-1:0] run_dly_i = '0;
    logic [DLY_W-1:0] rel_dly_i = '0;
    logic             go_req_o;
    logic             stop_clk_n_o;
    logic             wake_blk_o;
    logic [NLAT-1:0]  hold_o;

    int        cyc = 0;
    int        checks = 0;
    int        errors = 0;
    bit        done = 1'b0;
    exp_item_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    idle_exit_seq #(.DLY_W(DLY_W), .NLAT(NLAT), .SMGT_IDX(SMGT_IDX)) u_idle_exit_seq (
        .clk         (clk),
        .rst         (rst),
        .park_i      (park_i),
        .break_i     (break_i),
        .ack_i       (ack_i),
        .go_dly_i    (go_dly_i),
        .run_dly_i   (run_dly_i),
        .rel_dly_i   (rel_dly_i),
        .go_req_o    (go_req_o),
        .stop_clk_n_o(stop_clk_n_o),
        .wake_blk_o  (wake_blk_o),
        .hold_o      (hold_o)
    );

    function automatic void chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endfunction

    function automatic string ev_req(input int kind);
        case (kind)
            EV_PARK: return "R2";
            EV_GO:   return "R3";
            EV_RUN:  return "R4";
            default: return "R5";
        endcase
    endfunction

    // scoreboard monitor: pops one expected item per observed event
    function automatic void got(input int kind);
        exp_item_t it;
        if (exp_q.size() == 0) begin
            chk(1'b0, {ev_req(kind), "/R8 unexpected event"}, kind, -1);
            return;
        end
        it = exp_q.pop_front();
        chk(it.kind == kind, {ev_req(it.kind), " event kind"}, kind, it.kind);
        chk(it.cyc == cyc, {ev_req(it.kind), " event cycle"}, cyc, it.cyc);
        case (kind)
            EV_PARK: chk(hold_o == PARK_MASK, "R2/R6 hold on park", int'(hold_o), int'(PARK_MASK));
            EV_GO:   chk(wake_blk_o == 1'b1, "R7 block with go", int'(wake_blk_o), 1);
            EV_REL: begin
                chk(wake_blk_o == 1'b0, "R7 block drops on release", int'(wake_blk_o), 0);
                chk(stop_clk_n_o == 1'b1, "R5 running at release", int'(stop_clk_n_o), 1);
            end
            default: ;
        endcase
    endfunction

    logic            prev_stop = 1'b1;
    logic [NLAT-1:0] prev_hold = '0;

    always @(negedge clk) begin
        if (rst) begin
            prev_stop <= 1'b1;
            prev_hold <= '0;
        end else begin
            if (go_req_o) got(EV_GO);
            if (prev_stop && !stop_clk_n_o) got(EV_PARK);
            if (!prev_stop && stop_clk_n_o) got(EV_RUN);
            if (prev_hold != '0 && hold_o == '0) got(EV_REL);
            if (hold_o[SMGT_IDX]) chk(1'b0, "R6 interrupt line held", 1, 0);
            prev_stop <= stop_clk_n_o;
            prev_hold <= hold_o;
        end
    end

    function automatic void push(input int kind, input int at);
        exp_item_t it;
        it.kind = kind;
        it.cyc  = at;
        exp_q.push_back(it);
    endfunction

    task automatic pulse_park();
        @(negedge clk);
        park_i = 1'b1;
        push(EV_PARK, cyc + 1);
        @(negedge clk);
        park_i = 1'b0;
    endtask

    // stray strobes in the running state must do nothing (R8)
    task automatic noise_running();
        @(negedge clk);
        break_i = 1'b1;
        @(negedge clk);
        break_i = 1'b0;
        ack_i   = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(stop_clk_n_o == 1'b1, "R8 running ignores break/ack", int'(stop_clk_n_o), 1);
        chk(hold_o == '0, "R8 running hold untouched", int'(hold_o), 0);
    endtask

    task automatic run_seq(input int d_go, input int d_run, input int d_rel, input int gap, input bit noisy);
        int c_ack;
        go_dly_i  = DLY_W'(d_go);
        run_dly_i = DLY_W'(d_run);
        rel_dly_i = DLY_W'(d_rel);
        pulse_park();
        if (noisy) begin
            // acknowledge while parked without a request is ignored (R8)
            @(negedge clk);
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            repeat (3) @(negedge clk);
            chk(stop_clk_n_o == 1'b0, "R8 parked ignores ack", int'(stop_clk_n_o), 0);
            chk(go_req_o == 1'b0, "R8 parked ack no request", int'(go_req_o), 0);
        end
        repeat (2) @(negedge clk);
        break_i = 1'b1;
        push(EV_GO, cyc + d_go + 2);
        @(negedge clk);
        break_i = 1'b0;
        if (d_go == 0) begin
            @(negedge clk);
            chk(go_req_o == 1'b1, "R9 zero go delay", int'(go_req_o), 1);
        end
        while (!go_req_o) @(negedge clk);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            if (noisy && i == 0) begin
                break_i = 1'b1;
                park_i  = 1'b1;
            end else begin
                break_i = 1'b0;
                park_i  = 1'b0;
            end
        end
        break_i = 1'b0;
        park_i  = 1'b0;
        if (gap > 0) begin
            @(negedge clk);
            chk(stop_clk_n_o == 1'b0, "R4 no resume before ack", int'(stop_clk_n_o), 0);
            chk(wake_blk_o == 1'b1, "R7 block held while waiting", int'(wake_blk_o), 1);
        end
        ack_i = 1'b1;
        c_ack = cyc;
        push(EV_RUN, c_ack + d_run + 2);
        push(EV_REL, c_ack + d_run + 2 + d_rel + 1);
        @(negedge clk);
        ack_i = 1'b0;
        if (d_run == 0) begin
            @(negedge clk);
            chk(stop_clk_n_o == 1'b1, "R9 zero run delay", int'(stop_clk_n_o), 1);
        end
        while (hold_o != '0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all steps seen", exp_q.size(), 0);
        chk(wake_blk_o == 1'b0, "R7 block closed", int'(wake_blk_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(stop_clk_n_o == 1'b1, "R1 stop-clock in reset", int'(stop_clk_n_o), 1);
        chk(go_req_o == 1'b0, "R1 request in reset", int'(go_req_o), 0);
        chk(wake_blk_o == 1'b0, "R1 block in reset", int'(wake_blk_o), 0);
        chk(hold_o == '0, "R1 hold in reset", int'(hold_o), 0);
        rst = 1'b0;
        noise_running();
        run_seq(0, 0, 0, 0, 1'b0);   // R9 all-zero delays
        run_seq(3, 2, 5, 4, 1'b1);
        noise_running();
        run_seq(1, 7, 0, 1, 1'b1);
        run_seq(63, 63, 63, 12, 1'b0);
        run_seq(10, 0, 3, 2, 1'b1);
        noise_running();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule